// File: doc/BRIEF.md
# Single-Slope Fast PWM Timer

An 8-bit timer that counts upward on a divided clock and drives two pulse-width-modulated outputs. A prescaler turns the system clock into a one-cycle tick enable. On each tick the counter steps from zero up to a ceiling value and then returns to zero. The ceiling is either the full count of 255 or the active value of compare register A. Each output channel compares the count against its own compare value. A 2-bit mode field for each channel decides how that output reacts to a match and to the wrap.

Software sets up the block through a write-only strobe interface: a configuration byte, two compare bytes, an interrupt enable and a flag-clear location. Compare writes go into holding registers and take effect only when the counter wraps, so a period never sees half of an update. The overflow flag marks each wrap and can raise an interrupt request.

Top module: `fpwm_timer`

## Requirements
- R1: Configuration byte (address 0) bits [7:5] pick the clock select. 0 stops the counter. Values 1..7 make the counter advance once every 1, 8, 32, 64, 128, 256 or 1024 clock cycles.
- R2: On each tick the counter increments. When it equals the ceiling, the tick returns it to 0 instead.
- R3: Configuration bit 4 picks the ceiling: 0 gives 255, 1 gives the active compare A value.
- R4: Channel A mode is configuration bits [1:0] and channel B mode is bits [3:2]. Mode 0 holds the output low. Mode 2 (non-inverted) sets the output at the wrap and clears it at a match, so it is high for C+1 of every period's ticks.
- R5: Mode 3 (inverted) clears the output at the wrap and sets it at a match, giving the complement of mode 2.
- R6: Mode 1 toggles the output at each match, giving a 50% duty square wave with a period of two counter periods.
- R7: A compare value of 0 gives a one-tick spike per period. A compare value equal to the ceiling gives a constant output: high in mode 2 and low in mode 3.
- R8: Writes to compare A (address 1) and compare B (address 2) are held and become active at the next wrap.
- R9: The overflow flag is set by the tick that wraps the counter. Writing a 1 to address 4 bit 0 clears it. Writing 0 has no effect. A set in the same cycle as a clear wins.
- R10: The interrupt output equals the flag whenever address 3 bit 0 (interrupt enable) is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| count | output | 8 | Current counter value |
| pwm_a | output | 1 | Channel A waveform |
| pwm_b | output | 1 | Channel B waveform |
| ovf_flag | output | 1 | Overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the outputs can change only on a counter tick or in the cycle after a register write. They also assume that `wr_en` is a single-cycle strobe that is inactive during reset. The stimulus keeps to these rules: each write is driven at a falling edge, held for exactly one rising edge and then released. Only mapped addresses are used. After a mode, ceiling or compare change, the stimulus waits at least one full counter period before it measures, so that buffered values and output state have settled.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;

  typedef enum logic [1:0] {
    CH_OFF    = 2'd0,
    CH_TOGGLE = 2'd1,
    CH_NONINV = 2'd2,
    CH_INV    = 2'd3
  } ch_mode_e;

  localparam int ADR_CFG  = 0;
  localparam int ADR_CMPA = 1;
  localparam int ADR_CMPB = 2;
  localparam int ADR_IEN  = 3;
  localparam int ADR_FCLR = 4;

  localparam int NUM_CH = 2;

  // log2 of the division factor for clock select 1..7
  function automatic logic [3:0] div_shift(input logic [2:0] sel);
    case (sel)
      3'd2:    div_shift = 4'd3;
      3'd3:    div_shift = 4'd5;
      3'd4:    div_shift = 4'd6;
      3'd5:    div_shift = 4'd7;
      3'd6:    div_shift = 4'd8;
      3'd7:    div_shift = 4'd10;
      default: div_shift = 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/fpwm_prescaler.sv
module fpwm_prescaler
  import fpwm_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  output logic       tick
);

  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] limit;
  logic             at_limit;
  logic             running;

  assign running  = (sel != 3'd0);
  assign limit    = {PRE_W{1'b1}} >> (PRE_W - int'(div_shift(sel)));
  assign at_limit = (pcnt >= limit);
  assign tick     = running && at_limit;

  always_ff @(posedge clk) begin
    if (!rst_n)               pcnt <= '0;
    else if (!running || at_limit) pcnt <= '0;
    else                      pcnt <= pcnt + 1'b1;
  end

endmodule

// File: rtl/fpwm_regs.sv
module fpwm_regs
  import fpwm_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              load,
  input  logic              set_flag,
  output ch_mode_e          mode_a,
  output ch_mode_e          mode_b,
  output logic              top_sel,
  output logic [2:0]        clk_sel,
  output logic [CNT_W-1:0]  cmpa_act,
  output logic [CNT_W-1:0]  cmpb_act,
  output logic              ien,
  output logic              flag
);

  logic [CNT_W-1:0] cmpa_hold, cmpb_hold;
  logic             wr_cfg, wr_cmpa, wr_cmpb, wr_ien, wr_fclr;

  assign wr_cfg  = wr_en && (wr_addr == ADDR_W'(ADR_CFG));
  assign wr_cmpa = wr_en && (wr_addr == ADDR_W'(ADR_CMPA));
  assign wr_cmpb = wr_en && (wr_addr == ADDR_W'(ADR_CMPB));
  assign wr_ien  = wr_en && (wr_addr == ADDR_W'(ADR_IEN));
  assign wr_fclr = wr_en && (wr_addr == ADDR_W'(ADR_FCLR)) && wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_a  <= CH_OFF;
      mode_b  <= CH_OFF;
      top_sel <= 1'b0;
      clk_sel <= 3'd0;
    end else if (wr_cfg) begin
      mode_a  <= ch_mode_e'(wr_data[1:0]);
      mode_b  <= ch_mode_e'(wr_data[3:2]);
      top_sel <= wr_data[4];
      clk_sel <= wr_data[7:5];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmpa_hold <= '0;
      cmpb_hold <= '0;
    end else begin
      if (wr_cmpa) cmpa_hold <= wr_data;
      if (wr_cmpb) cmpb_hold <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmpa_act <= '0;
      cmpb_act <= '0;
    end else if (load) begin
      cmpa_act <= cmpa_hold;
      cmpb_act <= cmpb_hold;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        ien <= 1'b0;
    else if (wr_ien)   ien <= wr_data[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        flag <= 1'b0;
    else if (set_flag) flag <= 1'b1;
    else if (wr_fclr)  flag <= 1'b0;
  end

endmodule

// File: rtl/fpwm_counter.sv
module fpwm_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             top_sel,
  input  logic [CNT_W-1:0] cmpa_act,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] top_val,
  output logic             wrap
);

  assign top_val = top_sel ? cmpa_act : {CNT_W{1'b1}};
  assign wrap    = tick && (cnt == top_val);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (wrap)  cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/fpwm_channel.sv
module fpwm_channel
  import fpwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  ch_mode_e         mode,
  output logic             pwm
);

  logic wave_q;
  logic match;

  assign match = tick && (cnt == cmp);

  always_ff @(posedge clk) begin
    if (!rst_n) wave_q <= 1'b0;
    else begin
      case (mode)
        CH_TOGGLE: if (match) wave_q <= ~wave_q;
        CH_NONINV: begin
          if (wrap)       wave_q <= 1'b1;
          else if (match) wave_q <= 1'b0;
        end
        CH_INV: begin
          if (wrap)       wave_q <= 1'b0;
          else if (match) wave_q <= 1'b1;
        end
        default: wave_q <= wave_q;
      endcase
    end
  end

  assign pwm = (mode == CH_OFF) ? 1'b0 : wave_q;

endmodule

// File: rtl/fpwm_timer.sv
module fpwm_timer
  import fpwm_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 3,
  parameter int PRE_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  count,
  output logic              pwm_a,
  output logic              pwm_b,
  output logic              ovf_flag,
  output logic              irq
);

  ch_mode_e         mode_a, mode_b;
  logic             top_sel, ien, tick, wrap;
  logic [2:0]       clk_sel;
  logic [CNT_W-1:0] cmpa_act, cmpb_act, top_val;

  ch_mode_e         ch_mode [NUM_CH];
  logic [CNT_W-1:0] ch_cmp  [NUM_CH];
  logic [NUM_CH-1:0] ch_out;

  fpwm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .sel(clk_sel), .tick(tick)
  );

  fpwm_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load(wrap), .set_flag(wrap),
    .mode_a(mode_a), .mode_b(mode_b), .top_sel(top_sel), .clk_sel(clk_sel),
    .cmpa_act(cmpa_act), .cmpb_act(cmpb_act), .ien(ien), .flag(ovf_flag)
  );

  fpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .top_sel(top_sel),
    .cmpa_act(cmpa_act), .cnt(count), .top_val(top_val), .wrap(wrap)
  );

  assign ch_mode[0] = mode_a;
  assign ch_mode[1] = mode_b;
  assign ch_cmp[0]  = cmpa_act;
  assign ch_cmp[1]  = cmpb_act;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    fpwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wrap(wrap), .cnt(count),
      .cmp(ch_cmp[g]), .mode(ch_mode[g]), .pwm(ch_out[g])
    );
  end

  assign pwm_a = ch_out[0];
  assign pwm_b = ch_out[1];
  assign irq   = ien && ovf_flag;

endmodule

// File: rtl/fpwm_timer_chk.sv
module fpwm_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             tick,
  input logic [2:0]       clk_sel,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] top_val,
  input logic             ovf_flag,
  input logic             irq,
  input logic             pwm_a,
  input logic             pwm_b
);

  AST_STOPPED_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd0) |-> !tick);  // R1

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));  // R1

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count != top_val) |=> (count == $past(count) + 1'b1));  // R2

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == top_val) |=> (count == '0));  // R2

  AST_FLAG_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == top_val) |=> ovf_flag);  // R9

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf_flag);  // R10

  AST_A_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(pwm_a));  // R4

  AST_B_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(pwm_b));  // R4

endmodule

bind fpwm_timer fpwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tick(tick), .clk_sel(clk_sel),
  .count(count), .top_val(top_val), .ovf_flag(ovf_flag), .irq(irq),
  .pwm_a(pwm_a), .pwm_b(pwm_b)
);

// File: tb/sim_fpwm_timer.sv
module sim_fpwm_timer;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] count;
  logic       pwm_a, pwm_b, ovf_flag, irq;

  int nvec = 0;
  int nbad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpwm_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count(count), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .ovf_flag(ovf_flag), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(addr); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  // count high samples and rising edges of one channel over n cycles
  task automatic meas(input int ch, input int n, output int hi, output int rises);
    logic prev, cur;
    hi = 0; rises = 0;
    prev = (ch == 0) ? pwm_a : pwm_b;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cur = (ch == 0) ? pwm_a : pwm_b;
      if (cur) hi++;
      if (cur && !prev) rises++;
      prev = cur;
    end
  endtask

  task automatic wait_cnt(input int v);
    for (int i = 0; i < 3000; i++) begin
      if (count == 8'(v)) return;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R2 count after reset", count, 0);
    chk("R4 pwm_a after reset", pwm_a, 0);
    chk("R4 pwm_b after reset", pwm_b, 0);
    chk("R9 flag after reset", ovf_flag, 0);
    chk("R10 irq after reset", irq, 0);
    run(20);
    chk("R1 select 0 holds count", count, 0);
  endtask

  task automatic t_count;
    int c0;
    wr(0, 8'h20);
    run(3);
    for (int i = 0; i < 3; i++) begin
      c0 = count;
      @(negedge clk);
      chk("R2 step by one", count, (c0 + 1) % 256);
    end
    wait_cnt(255);
    @(negedge clk);
    chk("R2 wrap to zero", count, 0);
  endtask

  task automatic t_prescale;
    int c0, div;
    for (int s = 1; s < 8; s++) begin
      case (s)
        1: div = 1; 2: div = 8; 3: div = 32; 4: div = 64;
        5: div = 128; 6: div = 256; default: div = 1024;
      endcase
      wr(0, s << 5);
      run(2 * div);
      c0 = count;
      run(4 * div);
      chk($sformatf("R1 advance with select %0d", s), (count - c0) & 255, 4);
    end
  endtask

  task automatic t_noninv_inv;
    int hi, r;
    wr(1, 99); wr(2, 99);
    wr(0, 8'h20 | 2 | (3 << 2));
    run(600);
    meas(0, 512, hi, r);
    chk("R4 non-inverted high time", hi, 200);
    chk("R4 non-inverted period", r, 2);
    meas(1, 512, hi, r);
    chk("R5 inverted high time", hi, 312);
  endtask

  task automatic t_off;
    int hi, r;
    wr(0, 8'h20);
    run(3);
    meas(0, 512, hi, r);
    chk("R4 mode 0 holds A low", hi, 0);
    meas(1, 512, hi, r);
    chk("R4 mode 0 holds B low", hi, 0);
  endtask

  task automatic t_extreme;
    int hi, r;
    wr(1, 0); wr(2, 255);
    wr(0, 8'h20 | 2 | (3 << 2));
    run(600);
    meas(0, 512, hi, r);
    chk("R7 compare 0 spike", hi, 2);
    meas(1, 512, hi, r);
    chk("R7 inverted at max stays low", hi, 0);
    wr(0, 8'h20 | 3 | (2 << 2));
    run(600);
    meas(1, 512, hi, r);
    chk("R7 non-inverted at max stays high", hi, 512);
    meas(0, 512, hi, r);
    chk("R7 inverted compare 0 low spike", hi, 510);
  endtask

  task automatic t_toggle;
    int hi, r;
    wr(1, 50);
    wr(0, 8'h20 | 1);
    run(600);
    meas(0, 1024, hi, r);
    chk("R6 toggle duty", hi, 512);
    chk("R6 toggle period", r, 2);
  endtask

  task automatic t_topa;
    int hi, r, mx;
    wr(1, 99); wr(2, 49);
    wr(0, 8'h20 | 8'h10 | (2 << 2));
    run(600);
    meas(1, 200, hi, r);
    chk("R3 ceiling from A high time", hi, 100);
    chk("R3 ceiling from A period", r, 2);
    mx = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (count > mx) mx = count;
    end
    chk("R3 count peak equals compare A", mx, 99);
  endtask

  task automatic t_buffer;
    int mx;
    wr(1, 199);
    run(400);
    wait_cnt(10);
    wr(1, 50);
    mx = count;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (count == 0) break;
      if (count > mx) mx = count;
    end
    chk("R8 old ceiling kept until wrap", mx, 199);
    mx = 0;
    for (int i = 0; i < 204; i++) begin
      @(negedge clk);
      if (count > mx) mx = count;
    end
    chk("R8 new ceiling after wrap", mx, 50);
  endtask

  task automatic t_flag_irq;
    wr(1, 99);
    run(300);
    wr(3, 0);
    wait_cnt(40);
    chk("R10 irq masked while flag set", irq, 0);
    wr(4, 1);
    chk("R9 write 1 clears flag", ovf_flag, 0);
    wr(4, 0);
    wait_cnt(0);
    chk("R9 flag set at wrap", ovf_flag, 1);
    wr(4, 0);
    chk("R9 write 0 leaves flag", ovf_flag, 1);
    wr(3, 1);
    chk("R10 irq with enable", irq, 1);
    wr(4, 1);
    chk("R10 irq drops with flag", irq, 0);
  endtask

  task automatic finish_up;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nvec++; nbad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    run(4);
    rst_n = 1'b1;
    run(2);
    t_reset();
    t_count();
    t_prescale();
    t_noninv_inv();
    t_off();
    t_extreme();
    t_toggle();
    t_topa();
    t_buffer();
    t_flag_irq();
    finish_up();
  end

endmodule